// File: doc/BRIEF.md
# Mixed-Width RAM With Write-Through Registered Read

A small synchronous RAM with one write port and one read port on a single clock. The two ports may differ in width by a power-of-two factor. A parameter picks which of the two is the wide one. The write port carries one enable per group of adjacent bits. The storage is a plain array of narrow words. A wide port at address A covers narrow words A*2^L up to A*2^L + 2^L - 1, where L is the log2 width ratio. Sub-word k of the wide port sits in bits [k*NW +: NW].

The read path is a combinational array read followed by a data register. That register has a clock enable, a reset and a power-up value. The reset is synchronous or asynchronous, chosen by a parameter, never both. The read port is write-through. When the write port writes bits that the read port is reading on the same clock edge, the register captures the newly written bits. Bits that are not being written come from the old array contents.

Each narrow sub-word is compared separately. The address bits that select a sub-word inside the wide port are forced to that sub-word's index before the compare. One multiplexer is placed per write-enable group. No address register exists, so address bits that a wide port ties off carry no flip-flop.

Top module: `mwtr_ram`

## Requirements
- R1: On a clock edge, every write-enable group whose enable is high stores its write-data bits into the array. Enable bit s*(NW/EG)+g covers bits [s*NW+g*EG +: EG] of the write data. With the wide write port, those bits go to narrow word wr_addr*2^L+s.
- R2: With rd_ce high and no overlapping write, rd_data after the edge equals the array contents at rd_addr as they stood at that edge.
- R3: With rd_ce high and a write on the same edge to bits that the read address covers, rd_data after the edge shows the newly written bits.
- R4: In a same-address write with only some enable groups high, the bits of the disabled groups in rd_data keep the old array contents.
- R5: A write to another narrow sub-word of the same wide word, or to another address, has no effect on the bits captured by the read.
- R6: With rd_ce low, rd_data holds its value, while the write still updates the array.
- R7: With rd_rst high, rd_data becomes RST_VAL regardless of rd_ce or any colliding write. The array is not changed by the reset.
- R8: Before any capture, rd_data equals INIT_VAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rd_rst | input | 1 | Read register reset, active high; synchronous or asynchronous by RST_KIND |
| wr_addr | input | WAW | Write address in write-port words |
| wr_data | input | WW | Write data |
| wr_be | input | WW/EG | One write enable per EG-bit group |
| rd_addr | input | RAW | Read address in read-port words |
| rd_ce | input | 1 | Read register clock enable |
| rd_data | output | RW | Registered read data |

## Verification
The bench aims at same-edge collisions between the wide write and the narrow read. A design that compares the wide address without forcing the sub-word bits would bypass the wrong half, or both halves, and return another byte. Partial-enable collisions catch a bypass keyed on any enable rather than per group: the disabled nibble would show new data instead of old. Writes to the neighbouring sub-word of the same wide word catch an address compare that drops the low bit. Clock-enable-low and reset-during-collision cycles catch a register that lets the bypass or the array through when it should hold or load the reset value.

// File: rtl/mwtr_pkg.sv
package mwtr_pkg;
   typedef enum logic {RST_SYNC = 1'b0, RST_ASYNC = 1'b1} rst_kind_e;
endpackage

// File: rtl/mwtr_array.sv
module mwtr_array #(
   parameter int NW      = 8,
   parameter int NAW     = 5,
   parameter int RL      = 1,
   parameter bit WIDE_WR = 1'b1,
   parameter int EG      = 4,
   localparam int WW  = WIDE_WR ? (NW << RL) : NW,
   localparam int RW  = WIDE_WR ? NW : (NW << RL),
   localparam int WAW = WIDE_WR ? NAW - RL : NAW,
   localparam int RAW = WIDE_WR ? NAW : NAW - RL,
   localparam int NBE = WW / EG
) (
   input  logic           clk,
   input  logic [WAW-1:0] wr_addr,
   input  logic [WW-1:0]  wr_data,
   input  logic [NBE-1:0] wr_be,
   input  logic [RAW-1:0] rd_addr,
   output logic [RW-1:0]  rd_word
);
   localparam int DEPTH = 1 << NAW;
   localparam int GPN   = NW / EG;
   localparam int WSUB  = WIDE_WR ? (1 << RL) : 1;
   localparam int RSUB  = WIDE_WR ? 1 : (1 << RL);
   localparam int WSH   = WIDE_WR ? RL : 0;
   localparam int RSH   = WIDE_WR ? 0 : RL;

   logic [NW-1:0]  mem [DEPTH];
   logic [NAW-1:0] wbase;
   logic [NAW-1:0] rbase;

   assign wbase = NAW'(wr_addr) << WSH;
   assign rbase = NAW'(rd_addr) << RSH;

   // R1: group-wise storage update
   always_ff @(posedge clk) begin
      for (int s = 0; s < WSUB; s++) begin
         for (int g = 0; g < GPN; g++) begin
            if (wr_be[s*GPN+g])
               mem[wbase + NAW'(s)][g*EG +: EG] <= wr_data[s*NW+g*EG +: EG];
         end
      end
   end

   always_comb begin
      for (int s = 0; s < RSUB; s++)
         rd_word[s*NW +: NW] = mem[rbase + NAW'(s)];
   end
endmodule

// File: rtl/mwtr_bypass.sv
module mwtr_bypass #(
   parameter int NW      = 8,
   parameter int NAW     = 5,
   parameter int RL      = 1,
   parameter bit WIDE_WR = 1'b1,
   parameter int EG      = 4,
   localparam int WW  = WIDE_WR ? (NW << RL) : NW,
   localparam int RW  = WIDE_WR ? NW : (NW << RL),
   localparam int WAW = WIDE_WR ? NAW - RL : NAW,
   localparam int RAW = WIDE_WR ? NAW : NAW - RL,
   localparam int NBE = WW / EG
) (
   input  logic [RAW-1:0] rd_addr,
   input  logic [WAW-1:0] wr_addr,
   input  logic [WW-1:0]  wr_data,
   input  logic [NBE-1:0] wr_be,
   input  logic [RW-1:0]  arr_word,
   output logic [RW-1:0]  byp_word
);
   localparam int SUBS = 1 << RL;
   localparam int GPN  = NW / EG;

   logic [SUBS-1:0] hit;

   // per-sub-word address compare with the sub-word index forced in
   for (genvar s = 0; s < SUBS; s++) begin : g_sub
      if (WIDE_WR) begin : g_wide_wr
         assign hit[s] = NAW'(rd_addr) == ((NAW'(wr_addr) << RL) | NAW'(s));
      end else begin : g_wide_rd
         assign hit[s] = ((NAW'(rd_addr) << RL) | NAW'(s)) == NAW'(wr_addr);
      end
   end

   // one mux per enable group, chained over sub-words
   always_comb begin
      byp_word = arr_word;
      for (int s = 0; s < SUBS; s++) begin
         for (int g = 0; g < GPN; g++) begin
            if (hit[s] && wr_be[(WIDE_WR ? s : 0)*GPN+g])
               byp_word[(WIDE_WR ? 0 : s)*NW+g*EG +: EG] =
                  wr_data[(WIDE_WR ? s : 0)*NW+g*EG +: EG];
         end
      end
   end
endmodule

// File: rtl/mwtr_rdreg.sv
module mwtr_rdreg
   import mwtr_pkg::*;
#(
   parameter int          RW       = 8,
   parameter rst_kind_e   RST_KIND = RST_SYNC,
   parameter logic [63:0] RST_VAL  = 64'h5A,
   parameter logic [63:0] INIT_VAL = 64'hC3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic [RW-1:0] d,
   output logic [RW-1:0] q
);
   logic [RW-1:0] q_r = RW'(INIT_VAL);

   if (RST_KIND == RST_ASYNC) begin : g_arst
      always_ff @(posedge clk or posedge rst) begin
         if (rst)     q_r <= RW'(RST_VAL);
         else if (ce) q_r <= d;
      end
   end else begin : g_srst
      always_ff @(posedge clk) begin
         if (rst)     q_r <= RW'(RST_VAL);
         else if (ce) q_r <= d;
      end
   end

   assign q = q_r;

   // R7
   rst_load_chk: assert property (@(posedge clk) rst |=> (q_r == RW'(RST_VAL)));

   // R6
   ce_hold_chk: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(q_r));
endmodule

// File: rtl/mwtr_ram.sv
module mwtr_ram
   import mwtr_pkg::*;
#(
   parameter int          NW       = 8,
   parameter int          NAW      = 5,
   parameter int          RL       = 1,
   parameter bit          WIDE_WR  = 1'b1,
   parameter int          EG       = 4,
   parameter rst_kind_e   RST_KIND = RST_SYNC,
   parameter logic [63:0] RST_VAL  = 64'h5A,
   parameter logic [63:0] INIT_VAL = 64'hC3,
   localparam int WW  = WIDE_WR ? (NW << RL) : NW,
   localparam int RW  = WIDE_WR ? NW : (NW << RL),
   localparam int WAW = WIDE_WR ? NAW - RL : NAW,
   localparam int RAW = WIDE_WR ? NAW : NAW - RL,
   localparam int NBE = WW / EG
) (
   input  logic           clk,
   input  logic           rd_rst,
   input  logic [WAW-1:0] wr_addr,
   input  logic [WW-1:0]  wr_data,
   input  logic [NBE-1:0] wr_be,
   input  logic [RAW-1:0] rd_addr,
   input  logic           rd_ce,
   output logic [RW-1:0]  rd_data
);
   localparam int SUBS = 1 << RL;

   if (EG < 1 || NW % EG != 0) begin : g_bad_group
      $error("enable group width must divide the narrow width");
   end
   if (RL < 0 || RL >= NAW) begin : g_bad_ratio
      $error("width ratio must be below the address width");
   end
   if (RW > 64) begin : g_bad_width
      $error("read width above 64 bits is not supported");
   end

   logic [RW-1:0] arr_word;
   logic [RW-1:0] byp_word;

   mwtr_array #(.NW(NW), .NAW(NAW), .RL(RL), .WIDE_WR(WIDE_WR), .EG(EG)) array_i (
      .clk     (clk),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .rd_addr (rd_addr),
      .rd_word (arr_word)
   );

   mwtr_bypass #(.NW(NW), .NAW(NAW), .RL(RL), .WIDE_WR(WIDE_WR), .EG(EG)) bypass_i (
      .rd_addr  (rd_addr),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .arr_word (arr_word),
      .byp_word (byp_word)
   );

   mwtr_rdreg #(.RW(RW), .RST_KIND(RST_KIND), .RST_VAL(RST_VAL), .INIT_VAL(INIT_VAL)) rdreg_i (
      .clk (clk),
      .rst (rd_rst),
      .ce  (rd_ce),
      .d   (byp_word),
      .q   (rd_data)
   );

   // ---- checker state: a full-width write that lands on the read address
   logic          full_hit;
   logic [NW-1:0] slice_w;
   int unsigned   slice_sh;
   logic          chk_v   = 1'b0;
   logic [NW-1:0] chk_val = '0;
   int unsigned   chk_sh  = 0;

   always_comb begin
      if (WIDE_WR) begin
         full_hit = (NAW'(rd_addr) >> RL) == NAW'(wr_addr);
         slice_w  = NW'(wr_data >> ((int'(rd_addr) % SUBS) * NW));
         slice_sh = 0;
      end else begin
         full_hit = (NAW'(wr_addr) >> RL) == NAW'(rd_addr);
         slice_w  = NW'(wr_data);
         slice_sh = (int'(wr_addr) % SUBS) * NW;
      end
   end

   always_ff @(posedge clk) begin
      chk_v   <= rd_ce && !rd_rst && (&wr_be) && full_hit;
      chk_val <= slice_w;
      chk_sh  <= slice_sh;
   end

   // R3
   bypass_chk: assert property (@(posedge clk) disable iff (rd_rst)
      chk_v |-> (NW'(rd_data >> chk_sh) == chk_val));

   // R2
   arr_read_chk: assert property (@(posedge clk) disable iff (rd_rst)
      (rd_ce && wr_be == '0) |=> (rd_data == $past(arr_word)));
endmodule

// File: tb/mwtr_ram_tb_top.sv
`timescale 1ns/100ps
module mwtr_ram_tb_top;
   localparam logic [7:0] RSTV = 8'h5A;
   localparam logic [7:0] INIV = 8'hC3;

   typedef struct packed {
      logic [3:0]  wa;
      logic [15:0] wd;
      logic [3:0]  be;
      logic [4:0]  ra;
      logic        ce;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{4'h2, 16'hBEEF, 4'hF, 5'd4,  1'b1},
      '{4'h2, 16'h1234, 4'hF, 5'd5,  1'b1},
      '{4'h2, 16'h5678, 4'h3, 5'd5,  1'b1},
      '{4'h7, 16'hAAAA, 4'h8, 5'd15, 1'b1},
      '{4'h1, 16'h0000, 4'h0, 5'd3,  1'b1},
      '{4'h9, 16'hCAFE, 4'hF, 5'd18, 1'b1},
      '{4'h9, 16'h0F0F, 4'hF, 5'd19, 1'b0},
      '{4'h0, 16'h0000, 4'h0, 5'd19, 1'b1},
      '{4'hF, 16'h1357, 4'h6, 5'd30, 1'b1},
      '{4'hF, 16'h2468, 4'h9, 5'd31, 1'b1},
      '{4'hE, 16'hFFFF, 4'hF, 5'd30, 1'b1},
      '{4'h3, 16'h9999, 4'h2, 5'd6,  1'b1}
   };

   logic        clk = 1'b0;
   logic        rd_rst = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [4:0]  rd_addr = '0;
   logic        rd_ce = 1'b0;
   logic [7:0]  rd_data;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   logic [7:0] mdl [32];
   logic [7:0] exp_q = INIV;

   always #2.5 clk = ~clk;

   mwtr_ram #(.RST_VAL(64'h5A), .INIT_VAL(64'hC3)) dut_i (
      .clk     (clk),
      .rd_rst  (rd_rst),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .rd_addr (rd_addr),
      .rd_ce   (rd_ce),
      .rd_data (rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: rd_data=%h expected=%h", req, act, expv);
      end
   endtask

   // called at a falling edge; one clock per call
   task automatic step(input logic [3:0] wa, input logic [15:0] wd, input logic [3:0] be,
                       input logic [4:0] ra, input logic ce, input logic rst, input string tag);
      string t;
      bit    coll;
      wr_addr = wa; wr_data = wd; wr_be = be; rd_addr = ra; rd_ce = ce; rd_rst = rst;
      @(posedge clk);
      for (int s = 0; s < 2; s++)
         for (int g = 0; g < 2; g++)
            if (be[s*2+g]) mdl[wa*2+s][g*4 +: 4] = wd[s*8+g*4 +: 4];
      if (rst)     exp_q = RSTV;
      else if (ce) exp_q = mdl[ra];
      coll = (wa == ra[4:1]) && (be[ra[0]*2 +: 2] != 2'b00);
      t = tag;
      if (t == "") begin
         if (rst)       t = "R7";
         else if (!ce)  t = "R6";
         else if (coll) t = "R3";
         else           t = "R2";
      end
      @(negedge clk);
      check(t, rd_data, exp_q);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: rd_data=%h expected=%h", rd_data, exp_q);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #1;
      check("R8", rd_data, INIV);
      @(negedge clk);
      // fill the array with clock enable low: R6 hold, R1 storage
      for (int a = 0; a < 16; a++)
         step(4'(a), 16'(a * 16'h1357 ^ 16'h3C81), 4'hF, 5'd0, 1'b0, 1'b0, "R6");
      // reset beats enable and a colliding write
      step(4'h0, 16'hFFFF, 4'hF, 5'd0, 1'b1, 1'b1, "R7");
      step(4'h0, 16'h0000, 4'h0, 5'd0, 1'b0, 1'b1, "R7");
      // read back every narrow word, no writes
      for (int a = 0; a < 32; a++)
         step(4'h0, 16'h0000, 4'h0, 5'(a), 1'b1, 1'b0, "R1");
      // table of stimulus
      foreach (VECS[i])
         step(VECS[i].wa, VECS[i].wd, VECS[i].be, VECS[i].ra, VECS[i].ce, 1'b0, "");
      // R4: partial enable on the read sub-word, only low nibble written
      step(4'h3, 16'hFFFF, 4'h1, 5'd6, 1'b1, 1'b0, "R4");
      // R5: only the other sub-word of the same wide word is written
      step(4'h3, 16'h0000, 4'hC, 5'd6, 1'b1, 1'b0, "R5");
      // R5: another wide address entirely
      step(4'h4, 16'h0000, 4'hF, 5'd6, 1'b1, 1'b0, "R5");
      // R6: writes land while the register holds, then R1 read-back
      step(4'h5, 16'hD00D, 4'hF, 5'd10, 1'b0, 1'b0, "R6");
      step(4'h0, 16'h0000, 4'h0, 5'd10, 1'b1, 1'b0, "R1");
      step(4'h0, 16'h0000, 4'h0, 5'd11, 1'b1, 1'b0, "R1");
      // random mixed traffic with frequent collisions
      for (int k = 0; k < 300; k++) begin
         logic [4:0] ra;
         logic [3:0] wa;
         ra = 5'($urandom % 32);
         wa = ($urandom % 2 == 0) ? ra[4:1] : 4'($urandom % 16);
         step(wa, 16'($urandom), 4'($urandom), ra, ($urandom % 5) != 0,
              ($urandom % 40) == 0, "");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule